// File: doc/BRIEF.md
# Vector block context sequencer

This block is the control half of a scalar core's support for variable-length vector instruction blocks. When the decoder spots the opening opcode of such a block, the sequencer leaves scalar mode. It then walks a 2-bit phase register through the header sections as the decoder reports each one consumed. Once the predicate and register sections are in the vector context, it drives a block-relative instruction pointer through the opcode area.

The pointer counts 16-bit units, and zero addresses the first opcode after the header. Each retired opcode moves it forward by its own size. Reaching or passing the opcode count ends the block: the phase returns to scalar and the vector context is dropped. Software may redirect execution inside the block with an immediate CSR write to the pointer. Such a write is legal only in the run phase and only for a value inside the opcode range. Any other write is refused and raises an illegal-instruction flag. A trap return taken inside a block falls back one phase so that the context can be reloaded, and the pointer is kept.

Phase encoding on `status_o`: 2'b00 scalar, 2'b01 short header latched, 2'b10 length section latched, 2'b11 running.

Top module: `vblk_seq_top`

## Requirements
- R1: After reset `status_o` is 2'b00, `ptr_o` is 0, and `illegal_o`, `ctx_valid_o` and `blk_exit_o` are low.
- R2: In phase 2'b00 only `blk_start_i` has an effect: it moves the phase to 2'b01 and latches `hdr_i` onto `hdr_o`. `blk_start_i` is ignored in every other phase, and opcode completions and trap returns are ignored in phase 2'b00.
- R3: In phase 2'b01, `len_vld_i` moves the phase to 2'b10 and latches `len_i` (the opcode count in 16-bit units) onto `len_o`.
- R4: In phase 2'b10, `ctx_vld_i` moves the phase to 2'b11 with `ctx_valid_o` high. If the latched count is 0, it instead returns the phase to 2'b00 as an exit.
- R5: In phase 2'b11, `op_done_i` advances `ptr_o` by 1 when `op_is32_i` is low and by 2 when it is high. The pointer always stays below the opcode count.
- R6: When an advance would bring the pointer to the opcode count or beyond, the phase becomes 2'b00, `ptr_o` becomes 0 and `ctx_valid_o` falls. `blk_exit_o` is high for exactly that one cycle, and `hdr_o` and `len_o` keep their values.
- R7: A pointer write (`csr_wr_i`) in phase 2'b11 with a value below the opcode count loads that value and leaves the phase at 2'b11. A write in the same cycle as `op_done_i` takes precedence, so no advance is applied.
- R8: A pointer write with a value equal to or above the opcode count pulses `illegal_o` in the following cycle and leaves the pointer and the phase unchanged.
- R9: A pointer write of any value in a phase other than 2'b11 pulses `illegal_o` in the following cycle and changes nothing else.
- R10: `trap_ret_i` in phase 2'b11 moves the phase to 2'b10 and keeps `ptr_o`. The next `ctx_vld_i` resumes at 2'b11 at the same pointer. `trap_ret_i` in any other phase is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| blk_start_i | input | 1 | Decoder found a valid block-opening opcode |
| hdr_i | input | HDR_W | Short header fields carried by the opening opcode |
| len_vld_i | input | 1 | Length section consumed |
| len_i | input | PTR_W | Opcode count in 16-bit units |
| ctx_vld_i | input | 1 | Predicate and register sections loaded |
| op_done_i | input | 1 | An opcode inside the block retired |
| op_is32_i | input | 1 | Retired opcode is 32 bits wide |
| csr_wr_i | input | 1 | Immediate CSR write to the pointer |
| csr_wdata_i | input | PTR_W | Value written to the pointer |
| trap_ret_i | input | 1 | Return from trap |
| status_o | output | 2 | Current phase |
| ptr_o | output | PTR_W | Block-relative instruction pointer |
| ctx_valid_o | output | 1 | Vector context is live |
| illegal_o | output | 1 | Refused pointer write, one-cycle pulse |
| blk_exit_o | output | 1 | Block ended this cycle |
| hdr_o | output | HDR_W | Latched short header fields |
| len_o | output | PTR_W | Latched opcode count |

## Verification
The assertions check every cycle that the pointer stays inside the opcode range while running, and that a refused write leaves the pointer and phase frozen. They also check that any write outside the run phase is flagged, that a trap return steps back exactly one phase with the pointer intact, and that scalar mode can only lead to the header phase. The phase order across a whole block, the exact pointer value after mixed 16/32-bit steps, and a trap return that resumes at the saved pointer are shown only by the bench's scenarios. So are the write-over-advance precedence, the exit pulse width, the empty-block exit and the header and count values left after exit.

// File: rtl/vbs_pkg.sv
package vbs_pkg;
  typedef enum logic [1:0] {
    VB_SCALAR = 2'b00,
    VB_HDR    = 2'b01,
    VB_LEN    = 2'b10,
    VB_RUN    = 2'b11
  } vb_state_e;
endpackage

// File: rtl/vbs_wr_check.sv
module vbs_wr_check
  import vbs_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  vb_state_e          status_i,
  input  logic [PTR_W-1:0]   wdata_i,
  input  logic [PTR_W-1:0]   len_i,
  output logic               wr_ok_o
);
  logic in_range;

  always_comb begin
    in_range = (wdata_i < len_i);
    wr_ok_o  = (status_i == VB_RUN) && in_range;
  end
endmodule

// File: rtl/vbs_ptr_unit.sv
module vbs_ptr_unit #(
  parameter int PTR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_en_i,
  input  logic             op_is32_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] wdata_i,
  input  logic [PTR_W-1:0] len_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             end_o
);
  localparam int AW = PTR_W + 1;

  logic [PTR_W-1:0] ptr_q;
  logic [AW-1:0]    adv;
  logic [AW-1:0]    step;

  always_comb begin
    step  = op_is32_i ? AW'(2) : AW'(1);
    adv   = {1'b0, ptr_q} + step;
    end_o = adv_en_i && (adv >= {1'b0, len_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ptr_q <= '0;
    else if (load_i)    ptr_q <= wdata_i;
    else if (end_o)     ptr_q <= '0;
    else if (adv_en_i)  ptr_q <= adv[PTR_W-1:0];
  end

  assign ptr_o = ptr_q;

  assert_adv_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_en_i && !end_o && !load_i) |=> (ptr_q == $past(adv[PTR_W-1:0])));

  assert_end_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !load_i) |=> (ptr_q == '0));
endmodule

// File: rtl/vbs_status_fsm.sv
module vbs_status_fsm
  import vbs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      blk_start_i,
  input  logic      len_vld_i,
  input  logic      ctx_vld_i,
  input  logic      trap_ret_i,
  input  logic      end_i,
  input  logic      len_zero_i,
  output vb_state_e status_o,
  output logic      exit_o
);
  vb_state_e st_q, st_d;
  logic      exit_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      VB_SCALAR: if (blk_start_i) st_d = VB_HDR;
      VB_HDR:    if (len_vld_i)   st_d = VB_LEN;
      VB_LEN:    if (ctx_vld_i)   st_d = len_zero_i ? VB_SCALAR : VB_RUN;
      VB_RUN: begin
        if (trap_ret_i)  st_d = VB_LEN;
        else if (end_i)  st_d = VB_SCALAR;
      end
      default: st_d = VB_SCALAR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= VB_SCALAR;
      exit_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      exit_q <= (st_q != VB_SCALAR) && (st_d == VB_SCALAR);
    end
  end

  assign status_o = st_q;
  assign exit_o   = exit_q;

  assert_scalar_to_hdr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == VB_SCALAR) |=> (st_q == VB_SCALAR || st_q == VB_HDR));

  assert_run_from_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == VB_HDR) |=> (st_q != VB_RUN));
endmodule

// File: rtl/vblk_seq_top.sv
module vblk_seq_top
  import vbs_pkg::*;
#(
  parameter int PTR_W = 8,
  parameter int HDR_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_start_i,
  input  logic [HDR_W-1:0] hdr_i,
  input  logic             len_vld_i,
  input  logic [PTR_W-1:0] len_i,
  input  logic             ctx_vld_i,
  input  logic             op_done_i,
  input  logic             op_is32_i,
  input  logic             csr_wr_i,
  input  logic [PTR_W-1:0] csr_wdata_i,
  input  logic             trap_ret_i,
  output logic [1:0]       status_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             ctx_valid_o,
  output logic             illegal_o,
  output logic             blk_exit_o,
  output logic [HDR_W-1:0] hdr_o,
  output logic [PTR_W-1:0] len_o
);
  vb_state_e        status;
  logic [HDR_W-1:0] hdr_q;
  logic [PTR_W-1:0] len_q;
  logic [PTR_W-1:0] ptr;
  logic             illegal_q;
  logic             wr_ok, load, adv_en, blk_end, run;

  assign run    = (status == VB_RUN);
  assign load   = csr_wr_i && wr_ok;
  // the write is itself the retiring instruction, and a trap return pre-empts it
  assign adv_en = run && op_done_i && !csr_wr_i && !trap_ret_i;

  vbs_wr_check #(.PTR_W(PTR_W)) u_wr_check (
    .status_i (status),
    .wdata_i  (csr_wdata_i),
    .len_i    (len_q),
    .wr_ok_o  (wr_ok)
  );

  vbs_ptr_unit #(.PTR_W(PTR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_en_i  (adv_en),
    .op_is32_i (op_is32_i),
    .load_i    (load),
    .wdata_i   (csr_wdata_i),
    .len_i     (len_q),
    .ptr_o     (ptr),
    .end_o     (blk_end)
  );

  vbs_status_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .blk_start_i (blk_start_i),
    .len_vld_i   (len_vld_i),
    .ctx_vld_i   (ctx_vld_i),
    .trap_ret_i  (trap_ret_i),
    .end_i       (blk_end),
    .len_zero_i  (len_q == '0),
    .status_o    (status),
    .exit_o      (blk_exit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q     <= '0;
      len_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      if (status == VB_SCALAR && blk_start_i) hdr_q <= hdr_i;
      if (status == VB_HDR && len_vld_i)      len_q <= len_i;
      illegal_q <= csr_wr_i && !wr_ok;
    end
  end

  assign status_o    = status;
  assign ptr_o       = ptr;
  assign ctx_valid_o = run;
  assign illegal_o   = illegal_q;
  assign hdr_o       = hdr_q;
  assign len_o       = len_q;

  assert_ptr_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (ptr < len_q));

  assert_bad_wr_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && !wr_ok && !op_done_i && !trap_ret_i) |=> ($stable(ptr) && $stable(status)));

  assert_wr_out_of_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_wr_i && status != VB_RUN) |=> illegal_o);

  assert_trap_keeps_ptr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_ret_i && run && !csr_wr_i) |=> (status == VB_LEN && $stable(ptr)));

  assert_exit_clean_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_exit_o |-> (status == VB_SCALAR && ptr == '0 && !ctx_valid_o));
endmodule

// File: tb/tb_vblk_seq_top.sv
`timescale 1ns/1ps
module tb_vblk_seq_top;
  localparam int PTR_W = 8;
  localparam int HDR_W = 12;
  localparam int NV    = 24;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             blk_start_i = 0, len_vld_i = 0, ctx_vld_i = 0;
  logic             op_done_i = 0, op_is32_i = 0, csr_wr_i = 0, trap_ret_i = 0;
  logic [HDR_W-1:0] hdr_i = '0;
  logic [PTR_W-1:0] len_i = '0, csr_wdata_i = '0;
  logic [1:0]       status_o;
  logic [PTR_W-1:0] ptr_o, len_o;
  logic [HDR_W-1:0] hdr_o;
  logic             ctx_valid_o, illegal_o, blk_exit_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  vblk_seq_top #(.PTR_W(PTR_W), .HDR_W(HDR_W)) dut (.*);

  // op codes: 1 start, 2 len, 3 ctx, 4 op16, 5 op32, 6 wr, 7 trap_ret, 8 wr+op16
  // row: {op[3:0], arg[7:0], exp_status[1:0], exp_ptr[7:0], exp_illegal}
  localparam logic [22:0] VEC [NV] = '{
    {4'd1, 8'h5A, 2'd1, 8'd0, 1'b0},  // R2
    {4'd6, 8'd2,  2'd1, 8'd0, 1'b1},  // R9
    {4'd2, 8'd6,  2'd2, 8'd0, 1'b0},  // R3
    {4'd6, 8'd1,  2'd2, 8'd0, 1'b1},  // R9
    {4'd3, 8'd0,  2'd3, 8'd0, 1'b0},  // R4
    {4'd4, 8'd0,  2'd3, 8'd1, 1'b0},  // R5
    {4'd1, 8'd0,  2'd3, 8'd1, 1'b0},  // R2 start ignored
    {4'd5, 8'd0,  2'd3, 8'd3, 1'b0},  // R5
    {4'd6, 8'd6,  2'd3, 8'd3, 1'b1},  // R8 boundary
    {4'd6, 8'd5,  2'd3, 8'd5, 1'b0},  // R7 max legal
    {4'd6, 8'd1,  2'd3, 8'd1, 1'b0},  // R7 backward
    {4'd7, 8'd0,  2'd2, 8'd1, 1'b0},  // R10
    {4'd3, 8'd0,  2'd3, 8'd1, 1'b0},  // R10 resume
    {4'd8, 8'd4,  2'd3, 8'd4, 1'b0},  // R7 precedence
    {4'd4, 8'd0,  2'd3, 8'd5, 1'b0},  // R5
    {4'd4, 8'd0,  2'd0, 8'd0, 1'b0},  // R6 exact end
    {4'd6, 8'd0,  2'd0, 8'd0, 1'b1},  // R9
    {4'd4, 8'd0,  2'd0, 8'd0, 1'b0},  // R2 op ignored
    {4'd7, 8'd0,  2'd0, 8'd0, 1'b0},  // R10 ignored
    {4'd1, 8'h33, 2'd1, 8'd0, 1'b0},  // R2
    {4'd2, 8'd3,  2'd2, 8'd0, 1'b0},  // R3
    {4'd3, 8'd0,  2'd3, 8'd0, 1'b0},  // R4
    {4'd5, 8'd0,  2'd3, 8'd2, 1'b0},  // R5
    {4'd5, 8'd0,  2'd0, 8'd0, 1'b0}   // R6 overshoot
  };

  task automatic chk(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [7:0] arg);
    @(negedge clk_i);
    blk_start_i = (op == 1); hdr_i = {4'h0, arg};
    len_vld_i   = (op == 2); len_i = arg;
    ctx_vld_i   = (op == 3);
    op_done_i   = (op == 4) || (op == 5) || (op == 8);
    op_is32_i   = (op == 5);
    csr_wr_i    = (op == 6) || (op == 8); csr_wdata_i = arg;
    trap_ret_i  = (op == 7);
    @(posedge clk_i);
    #1;
    blk_start_i = 0; len_vld_i = 0; ctx_vld_i = 0; op_done_i = 0;
    op_is32_i = 0; csr_wr_i = 0; trap_ret_i = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 status", status_o, 0);
    chk("R1 ptr", ptr_o, 0);
    chk("R1 illegal", illegal_o, 0);
    chk("R1 ctx_valid", ctx_valid_o, 0);
    chk("R1 exit", blk_exit_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22:19], VEC[i][18:11]);
      chk($sformatf("row%0d status", i), status_o, VEC[i][10:9]);
      chk($sformatf("row%0d ptr", i), ptr_o, VEC[i][8:1]);
      chk($sformatf("row%0d illegal", i), illegal_o, VEC[i][0]);
      chk($sformatf("row%0d ctx_valid", i), ctx_valid_o, VEC[i][10:9] == 2'd3);
    end
    chk("R6 exit pulse at overshoot", blk_exit_o, 1);
    chk("R6 hdr kept", hdr_o, 12'h033);
    chk("R6 len kept", len_o, 3);
    step(4'd0, 8'd0);
    chk("R6 exit pulse one cycle", blk_exit_o, 0);

    step(4'd1, 8'hC7);
    chk("R2 hdr latched", hdr_o, 12'h0C7);
    step(4'd2, 8'd0);
    chk("R3 len latched", len_o, 0);
    step(4'd3, 8'd0);
    chk("R4 empty block status", status_o, 0);
    chk("R4 empty block exit", blk_exit_o, 1);
    chk("R4 empty ctx_valid", ctx_valid_o, 0);

    step(4'd1, 8'h01);
    step(4'd2, 8'd2);
    step(4'd2, 8'd9);
    chk("R3 len ignored past hdr", len_o, 2);
    step(4'd7, 8'd0);
    chk("R10 trap ignored in len phase", status_o, 2);
    step(4'd3, 8'd0);
    step(4'd6, 8'd2);
    chk("R8 write at count", illegal_o, 1);
    chk("R8 ptr frozen", ptr_o, 0);
    step(4'd0, 8'd0);
    chk("R8 illegal one cycle", illegal_o, 0);
    step(4'd5, 8'd0);
    chk("R6 exit by 32-bit", status_o, 0);
    chk("R6 exit flag", blk_exit_o, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule